// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block holds the control and status register of a multi-channel analog-to-digital converter and runs its conversion sequence. Software reaches the 8-bit register through a simple register bus that has read and write strobes. The register carries an end-of-conversion flag, an interrupt enable, a start bit, a reserved bit and a 4-bit channel field. A separate mode input chooses between one conversion on one channel and a repeating scan over a range of channels.

The block sends a one-cycle start request with a channel number to an external converter core and waits for that core's done pulse. It sets the end flag when a conversion pass completes. It raises an interrupt while the flag and the enable are both set. It clears the flag through a guarded software handshake, or when a DMA engine, started by that interrupt, reads the conversion result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, and irq and conv_start are 0. The read layout is bit 7 end flag, bit 6 interrupt enable, bit 5 start, bit 4 reserved, bits 3:0 channel field.
- R2: Bit 4 always reads 0. A write of 1 to bit 4 has no effect.
- R3: A write with bit 5 set while idle raises conv_start for exactly one cycle, in the second cycle after the write. conv_chan is valid in that cycle.
- R4: In single mode (scan_mode=0) one conversion runs on the channel in bits 3:0. Its done pulse sets the end flag and clears bit 5, and no further start request follows.
- R5: In scan mode (scan_mode=1) conversions run on channels 0, 1, ... up to the value in bits 3:0, then wrap to 0. The end flag is set by the done pulse of that last channel, and bit 5 stays 1.
- R6: A write with bit 5 clear stops the sequence. No start request follows it, and a later done pulse does not set the end flag.
- R7: A write with bit 7 clear clears the end flag only when a register read has returned the flag as 1 since the last write. A write with bit 7 set never changes the flag.
- R8: Any write, whatever its data, cancels a preceding read of the flag as 1. A later write of 0 to bit 7 then leaves the flag set.
- R9: irq is 1 exactly while the end flag and the interrupt enable are both 1.
- R10: A dma_rd pulse clears the end flag while irq is 1. A dma_rd pulse has no effect while irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| scan_mode | input | 1 | 0 = single conversion, 1 = repeating scan |
| dma_rd | input | 1 | DMA read of the conversion result |
| conv_done | input | 1 | Converter core finished the current conversion |
| conv_start | output | 1 | One-cycle start request to the converter core |
| conv_chan | output | 4 | Channel for the current request |
| irq | output | 1 | Conversion-end interrupt |

## Verification
Random runs vary the mode, the channel field, the interrupt enable, the reserved bit and the delay of the converter's done pulse. Comparing the observed channel order with the expected order separates single mode from scan mode and shows the wrap to channel 0. Directed cases try the flag-clear handshake with and without a preceding read, with a write placed between the read and the clear, and with a write of 1 to the flag. They also try DMA reads with the interrupt masked and unmasked, and a stop in the middle of a scan followed by a late done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CSR_W  = 8;
    localparam int CHAN_W = 4;

    typedef struct packed {
        logic              eflag;
        logic              ien;
        logic              run;
        logic              rsvd;
        logic [CHAN_W-1:0] chsel;
    } csr_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } seq_st_e;

    // Register image as seen on the bus: reserved bit forced low.
    function automatic csr_t csr_view(input csr_t c);
        csr_t v;
        v      = c;
        v.rsvd = 1'b0;
        return v;
    endfunction

    // Channel for the next request: scan walks a pointer, single uses the field.
    function automatic logic [CHAN_W-1:0] pick_chan(input logic scan,
                                                    input logic [CHAN_W-1:0] ptr,
                                                    input logic [CHAN_W-1:0] sel);
        return scan ? ptr : sel;
    endfunction

    // Scan pointer after a conversion on chan with upper bound sel.
    function automatic logic [CHAN_W-1:0] next_ptr(input logic [CHAN_W-1:0] chan,
                                                   input logic [CHAN_W-1:0] sel);
        return (chan >= sel) ? '0 : chan + 1'b1;
    endfunction

endpackage

// File: rtl/adc_csr_regs.sv
module adc_csr_regs
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic wr,
    input  csr_t wdata,
    input  logic dma_rd,
    input  logic hw_set,
    input  logic hw_run_clr,
    output csr_t q,
    output logic irq
);

    logic armed;

    assign irq = q.eflag & q.ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            armed <= 1'b0;
        end else begin
            if (wr) begin
                q.ien   <= wdata.ien;
                q.run   <= wdata.run;
                q.chsel <= wdata.chsel;
                armed   <= 1'b0;
            end else begin
                if (rd && q.eflag) armed <= 1'b1;
                if (hw_run_clr)    q.run <= 1'b0;
            end
            // Hardware completion takes priority over any clear.
            if (hw_set)
                q.eflag <= 1'b1;
            else if ((wr && !wdata.eflag && armed) || (dma_rd && irq))
                q.eflag <= 1'b0;
            q.rsvd <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              scan,
    input  logic [CHAN_W-1:0] chsel,
    input  logic              done,
    output logic              start,
    output logic [CHAN_W-1:0] chan,
    output logic              set_flag,
    output logic              run_clr
);

    seq_st_e           state;
    logic [CHAN_W-1:0] ptr;
    logic              fin;

    assign fin      = (state == SQ_BUSY) && run && done;
    assign set_flag = fin && (!scan || chan >= chsel);
    assign run_clr  = fin && !scan;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            chan  <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (run) begin
                        start <= 1'b1;
                        chan  <= pick_chan(scan, ptr, chsel);
                        state <= SQ_BUSY;
                    end else begin
                        ptr <= '0;
                    end
                end
                default: begin
                    if (!run) begin
                        state <= SQ_IDLE;
                        ptr   <= '0;
                    end else if (done) begin
                        state <= SQ_IDLE;
                        if (scan) ptr <= next_ptr(chan, chsel);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [CSR_W-1:0]  reg_wdata,
    output logic [CSR_W-1:0]  reg_rdata,
    input  logic              scan_mode,
    input  logic              dma_rd,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              irq
);

    csr_t csr_q;
    csr_t csr_w;
    logic seq_set;
    logic seq_run_clr;

    assign csr_w     = csr_t'(reg_wdata);
    assign reg_rdata = csr_view(csr_q);

    adc_csr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .rd         (reg_rd),
        .wr         (reg_wr),
        .wdata      (csr_w),
        .dma_rd     (dma_rd),
        .hw_set     (seq_set),
        .hw_run_clr (seq_run_clr),
        .q          (csr_q),
        .irq        (irq)
    );

    adc_seq_fsm u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (csr_q.run),
        .scan     (scan_mode),
        .chsel    (csr_q.chsel),
        .done     (conv_done),
        .start    (conv_start),
        .chan     (conv_chan),
        .set_flag (seq_set),
        .run_clr  (seq_run_clr)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       scan_mode,
    input logic       dma_rd,
    input logic       conv_done,
    input logic       conv_start,
    input logic [3:0] conv_chan,
    input logic       irq
);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[4] == 1'b0);

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_flag_from_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rdata[7]) |-> $past(conv_done));

    p_single_autoclr_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(reg_rdata[5]) && !$past(reg_wr)) |-> ($past(conv_done) && !$past(scan_mode)));

    p_chan_bound_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (conv_chan <= reg_rdata[3:0]));

    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[5]) |=> !reg_rdata[5]);

    p_w1_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[7] && !reg_rdata[7] && !conv_done) |=> !reg_rdata[7]);

    p_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && !conv_done && !dma_rd) |=> $stable(reg_rdata));

    p_dma_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (dma_rd && irq && !conv_done) |=> !reg_rdata[7]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scan_mode = 1'b0, dma_rd = 1'b0, conv_done = 1'b0;
    logic       conv_start;
    logic [3:0] conv_chan;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (.*);

    function automatic logic [3:0] exp_chan(input logic scan, input logic [3:0] sel, input int idx);
        return scan ? 4'(idx % (int'(sel) + 1)) : sel;
    endfunction

    function automatic logic [7:0] mk(input logic f, input logic ie, input logic st,
                                      input logic rs, input logic [3:0] sel);
        return {f, ie, st, rs, sel};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic dma_pulse();
        @(negedge clk); dma_rd = 1'b1;
        @(negedge clk); dma_rd = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    // Wait for a start request, then answer with a done pulse after a random delay.
    task automatic convert(output logic [3:0] ch);
        int n = 0;
        ch = 4'hx;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_start && n < 20);
        chk("R3 start request seen", int'(conv_start), 1);
        ch = conv_chan;
        repeat ($urandom % 4) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic quiet(input string tag, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [3:0] ch;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R1 reset register", int'(reg_rdata), 8'h00);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset start", int'(conv_start), 0);

        wr(8'h10);
        chk("R2 reserved write ignored", int'(reg_rdata), 8'h00);

        // R3: one-cycle request timing, single mode on channel 9
        scan_mode = 1'b0;
        wr(8'h29);
        chk("R3 no request in first cycle", int'(conv_start), 0);
        @(negedge clk);
        chk("R3 request in second cycle", int'(conv_start), 1);
        chk("R3 request channel", int'(conv_chan), 9);
        @(negedge clk);
        chk("R3 request lasts one cycle", int'(conv_start), 0);
        done_pulse();
        chk("R4 single flag and auto clear", int'(reg_rdata), 8'h89);

        // R7 / R8: clear handshake
        wr(8'h09);
        chk("R7 write 0 without read keeps flag", int'(reg_rdata[7]), 1);
        wr(8'h89);
        chk("R7 write 1 keeps flag", int'(reg_rdata[7]), 1);
        rd(v);
        chk("R7 read returns flag", int'(v[7]), 1);
        wr(8'h89);
        wr(8'h09);
        chk("R8 intervening write cancels read", int'(reg_rdata[7]), 1);
        rd(v);
        wr(8'h09);
        chk("R7 read then write 0 clears", int'(reg_rdata[7]), 0);

        // R10 / R9: DMA clear gated by interrupt
        wr(8'h25);
        convert(ch);
        chk("R10 flag set for dma test", int'(reg_rdata[7]), 1);
        chk("R9 irq masked", int'(irq), 0);
        dma_pulse();
        chk("R10 dma ignored while irq low", int'(reg_rdata[7]), 1);
        wr(8'hC5);
        chk("R9 irq with flag and enable", int'(irq), 1);
        dma_pulse();
        chk("R10 dma clears flag", int'(reg_rdata[7]), 0);
        chk("R9 irq drops with flag", int'(irq), 0);

        // R6: stop in the middle of a scan
        scan_mode = 1'b1;
        wr(8'h23);
        convert(ch);
        chk("R5 scan begins at channel 0", int'(ch), 0);
        wr(8'h03);
        chk("R6 start bit cleared", int'(reg_rdata[5]), 0);
        repeat (2) @(negedge clk);
        done_pulse();
        chk("R6 late done ignored", int'(reg_rdata[7]), 0);
        quiet("R6 no request after stop", 8);

        // Random runs
        for (int it = 0; it < 30; it++) begin
            logic       m, ie, rs;
            logic [3:0] sel;
            int         n;
            m   = 1'($urandom % 2);
            ie  = 1'($urandom % 2);
            rs  = 1'($urandom % 2);
            sel = m ? 4'($urandom % 6) : 4'($urandom % 16);
            n   = m ? int'(sel) + 1 : 1;
            scan_mode = m;
            wr(mk(1'b0, ie, 1'b1, rs, sel));
            chk("R2 reserved reads 0", int'(reg_rdata[4]), 0);
            for (int k = 0; k < n; k++) begin
                if (k > 0) chk("R5 flag waits for last channel", int'(reg_rdata[7]), 0);
                convert(ch);
                chk(m ? "R5 scan channel order" : "R4 single channel", int'(ch), int'(exp_chan(m, sel, k)));
            end
            chk(m ? "R5 flag after last channel" : "R4 flag after conversion", int'(reg_rdata[7]), 1);
            chk("R9 irq follows enable", int'(irq), int'(ie));
            chk(m ? "R5 start stays set" : "R4 start cleared", int'(reg_rdata[5]), int'(m));
            if (m) begin
                convert(ch);
                chk("R5 wrap to channel 0", int'(ch), 0);
                wr(mk(1'b1, ie, 1'b0, 1'b0, sel));
                repeat (3) @(negedge clk);
                quiet("R6 stopped scan idle", 5);
            end else begin
                quiet("R4 no further request", 5);
            end
            if (ie && ($urandom % 2 == 1)) begin
                dma_pulse();
                chk("R10 dma clear", int'(reg_rdata[7]), 0);
            end else begin
                rd(v);
                wr(mk(1'b0, ie, 1'b0, 1'b0, sel));
                chk("R7 handshake clear", int'(reg_rdata[7]), 0);
            end
            chk("R9 irq low after clear", int'(irq), 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule